// File: doc/BRIEF.md
# Strobed Write-Cycle Bus Master

This block runs one external write transfer at a time on an asynchronous bus that uses an address strobe and a data strobe. A client offers a write request made of a 24-bit address, a 3-bit function code, a 2-bit operand size and a 16-bit data word. The block accepts the request only while it is idle. It then steps through six numbered bus states, S0 to S5, one clock each. The one exception is S3, where it holds the data strobe asserted until the slave acknowledges on a two-bit active-low acknowledge input. After the cycle ends, the block raises a single-cycle done pulse.

The acknowledge input is asynchronous and passes through a flop synchronizer before the sequencer uses it. The sequencer measures how long it waited in S3. If the acknowledge was first recognised late, it inserts the optional S4 state, which changes nothing on the bus, before the terminating state. The block does not begin a new S0 while any acknowledge bit from the previous transfer is still asserted.

Top module: `wrbus_master`

## Requirements
- R1: After reset, `as_n` and `ds_n` are high, `bus_data_oe` is low, `bus_rnw` is high, `done` is low and `req_ready` is high (no acknowledge bit asserted).
- R2: A transfer starts with exactly one S0 cycle. In S0, `bus_rnw` is low and `bus_addr`, `bus_fc` and `bus_siz` carry the accepted request while `as_n` is still high. These three fields stay stable for the whole transfer.
- R3: `as_n` goes low in the cycle after S0 (S1). `bus_data_oe` goes high one cycle later (S2) with the request data on `bus_data`. `bus_data` reads zero whenever `bus_data_oe` is low.
- R4: `ds_n` goes low in the cycle after data is placed (S3) and stays low until an acknowledge is recognised. An acknowledge is any bit of `ack_n` at 0, seen through `SYNC_STAGES` synchronizer flops.
- R5: If the acknowledge is recognised after fewer than `LATE_WAITS` S3 cycles, the next state is S5. With the defaults, an acknowledge driven D cycles after `ds_n` falls (D < 2) gives `ds_n` low for D+3 cycles.
- R6: If the acknowledge is recognised after `LATE_WAITS` or more S3 cycles (and `USE_S4` is set), one S4 cycle is inserted with all bus outputs unchanged. This gives `ds_n` low for D+4 cycles (D ≥ 2 at the defaults).
- R7: In S5, `as_n` and `ds_n` rise and `bus_data_oe` falls in the same cycle, while `bus_rnw` is still low. In the following idle cycle `bus_rnw` returns high.
- R8: `done` is high for exactly one cycle, the cycle right after S5.
- R9: A request is accepted only when `req_valid` and `req_ready` are both high. A `req_valid` pulse during a transfer starts no further transfer and does not alter the driven address.
- R10: `req_ready` is low while any synchronized acknowledge bit is asserted, and no S0 starts in that time. It rises `SYNC_STAGES` cycles after `ack_n` returns to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Idle and no acknowledge pending; request taken on this cycle |
| req_addr | input | 24 | Request address |
| req_fc | input | 3 | Request function code |
| req_siz | input | 2 | Request operand size |
| req_data | input | 16 | Request write data |
| done | output | 1 | One-cycle pulse after the transfer terminates |
| bus_addr | output | 24 | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_siz | output | 2 | Bus operand size |
| bus_data | output | 16 | Bus write data (zero when not enabled) |
| bus_data_oe | output | 1 | Data output enable |
| bus_rnw | output | 1 | Read/write line, low for a write transfer |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| ack_n | input | 2 | Asynchronous transfer acknowledge, active low per bit |

## Verification
Two functions can meet in one cycle. The first is termination of one transfer while the acknowledge from that same transfer is still held. The second is acceptance of the next request. The bench provokes this by keeping `ack_n` asserted past `done` while holding `req_valid` high. It judges the result by seeing that `req_ready` stays low and `bus_rnw` stays high, and that `req_ready` returns exactly `SYNC_STAGES` cycles after release. In a separate case, a request pulse lands in S1/S2 of a running transfer, and the bench confirms that no second start follows `done`.

// File: rtl/wrbus_pkg.sv
package wrbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_S0   = 3'd1,
        ST_S1   = 3'd2,
        ST_S2   = 3'd3,
        ST_S3   = 3'd4,
        ST_S4   = 3'd5,
        ST_S5   = 3'd6
    } wr_state_e;

    // a transfer owns the bus from S0 through S5
    function automatic logic st_active(wr_state_e s);
        return s != ST_IDLE;
    endfunction

    function automatic logic st_addr_strobe(wr_state_e s);
        return (s == ST_S1) || (s == ST_S2) || (s == ST_S3) || (s == ST_S4);
    endfunction

    function automatic logic st_data_drive(wr_state_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_S4);
    endfunction

    function automatic logic st_data_strobe(wr_state_e s);
        return (s == ST_S3) || (s == ST_S4);
    endfunction

endpackage

// File: rtl/wrbus_ack_sync.sv
module wrbus_ack_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ack_n_in,
    output logic             ack_any
);

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] sync_d;
            logic [WIDTH-1:0] sync_q;
            if (g == 0) begin : g_first
                always_comb sync_d = ack_n_in;
            end else begin : g_next
                always_comb sync_d = g_stage[g-1].sync_q;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= sync_d;
            end
        end
    endgenerate

    // any low bit at the last stage counts as acknowledge
    assign ack_any = |(~g_stage[STAGES-1].sync_q);

endmodule

// File: rtl/wrbus_wait_timer.sv
module wrbus_wait_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    input  logic ack_any,
    output logic late
);

    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!in_wait) begin
            cnt_d = '0;
        end else if (!ack_any && (cnt_q < CW'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign late = (cnt_q >= CW'(LIMIT));

endmodule

// File: rtl/wrbus_seq.sv
module wrbus_seq
    import wrbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3,
    parameter int SIZ_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FC_W-1:0]   req_fc,
    input  logic [SIZ_W-1:0]  req_siz,
    input  logic [DATA_W-1:0] req_data,
    input  logic              ack_any,
    input  logic              late,
    output logic              req_ready,
    output wr_state_e         state,
    output logic [ADDR_W-1:0] addr,
    output logic [FC_W-1:0]   fc,
    output logic [SIZ_W-1:0]  siz,
    output logic [DATA_W-1:0] data,
    output logic              done
);

    typedef struct packed {
        wr_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
        logic [SIZ_W-1:0]  siz;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    assign req_ready = (r_q.st == ST_IDLE) && !ack_any;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    r_d.st   = ST_S0;
                    r_d.addr = req_addr;
                    r_d.fc   = req_fc;
                    r_d.siz  = req_siz;
                    r_d.data = req_data;
                end
            end
            ST_S0: r_d.st = ST_S1;
            ST_S1: r_d.st = ST_S2;
            ST_S2: r_d.st = ST_S3;
            ST_S3: begin
                if (ack_any) r_d.st = late ? ST_S4 : ST_S5;
            end
            ST_S4: r_d.st = ST_S5;
            ST_S5: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state = r_q.st;
    assign addr  = r_q.addr;
    assign fc    = r_q.fc;
    assign siz   = r_q.siz;
    assign data  = r_q.data;
    assign done  = r_q.done;

endmodule

// File: rtl/wrbus_drive.sv
module wrbus_drive
    import wrbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3,
    parameter int SIZ_W  = 2,
    parameter int DATA_W = 16
) (
    input  wr_state_e         state,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FC_W-1:0]   fc,
    input  logic [SIZ_W-1:0]  siz,
    input  logic [DATA_W-1:0] data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic [SIZ_W-1:0]  bus_siz,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_rnw,
    output logic              as_n,
    output logic              ds_n
);

    always_comb begin
        bus_addr    = addr;
        bus_fc      = fc;
        bus_siz     = siz;
        bus_rnw     = !st_active(state);
        as_n        = !st_addr_strobe(state);
        ds_n        = !st_data_strobe(state);
        bus_data_oe = st_data_drive(state);
        bus_data    = bus_data_oe ? data : '0;
    end

endmodule

// File: rtl/wrbus_master.sv
module wrbus_master
    import wrbus_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int FC_W        = 3,
    parameter int SIZ_W       = 2,
    parameter int DATA_W      = 16,
    parameter int ACK_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LATE_WAITS  = 4,
    parameter bit USE_S4      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [FC_W-1:0]   req_fc,
    input  logic [SIZ_W-1:0]  req_siz,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic [SIZ_W-1:0]  bus_siz,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic              bus_rnw,
    output logic              as_n,
    output logic              ds_n,
    input  logic [ACK_W-1:0]  ack_n
);

    logic              ack_any;
    logic              late;
    wr_state_e         state;
    logic [ADDR_W-1:0] addr;
    logic [FC_W-1:0]   fc;
    logic [SIZ_W-1:0]  siz;
    logic [DATA_W-1:0] data;

    wrbus_ack_sync #(.WIDTH(ACK_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n_in (ack_n),
        .ack_any  (ack_any)
    );

    generate
        if (USE_S4) begin : g_timer
            wrbus_wait_timer #(.LIMIT(LATE_WAITS)) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_wait (state == ST_S3),
                .ack_any (ack_any),
                .late    (late)
            );
        end else begin : g_no_timer
            assign late = 1'b0;
        end
    endgenerate

    wrbus_seq #(.ADDR_W(ADDR_W), .FC_W(FC_W), .SIZ_W(SIZ_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_fc    (req_fc),
        .req_siz   (req_siz),
        .req_data  (req_data),
        .ack_any   (ack_any),
        .late      (late),
        .req_ready (req_ready),
        .state     (state),
        .addr      (addr),
        .fc        (fc),
        .siz       (siz),
        .data      (data),
        .done      (done)
    );

    wrbus_drive #(.ADDR_W(ADDR_W), .FC_W(FC_W), .SIZ_W(SIZ_W), .DATA_W(DATA_W)) u_drive (
        .state       (state),
        .addr        (addr),
        .fc          (fc),
        .siz         (siz),
        .data        (data),
        .bus_addr    (bus_addr),
        .bus_fc      (bus_fc),
        .bus_siz     (bus_siz),
        .bus_data    (bus_data),
        .bus_data_oe (bus_data_oe),
        .bus_rnw     (bus_rnw),
        .as_n        (as_n),
        .ds_n        (ds_n)
    );

endmodule

// File: rtl/wrbus_master_chk.sv
module wrbus_master_chk #(
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3,
    parameter int SIZ_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FC_W-1:0]   bus_fc,
    input logic [SIZ_W-1:0]  bus_siz,
    input logic              bus_data_oe,
    input logic              bus_rnw,
    input logic              as_n,
    input logic              ds_n
);

    AST_AS_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> !bus_rnw); // R2

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rnw && $past(!bus_rnw)) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_siz))); // R2

    AST_AS_AFTER_S0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rnw) |=> $fell(as_n)); // R3

    AST_OE_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !as_n); // R3

    AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> (!as_n && bus_data_oe)); // R4

    AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n) |-> (ds_n && !bus_data_oe && !bus_rnw)); // R7

    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n) |=> done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rnw) |-> $past(req_valid && req_ready)); // R9

endmodule

bind wrbus_master wrbus_master_chk #(
    .ADDR_W (ADDR_W),
    .FC_W   (FC_W),
    .SIZ_W  (SIZ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .bus_addr    (bus_addr),
    .bus_fc      (bus_fc),
    .bus_siz     (bus_siz),
    .bus_data_oe (bus_data_oe),
    .bus_rnw     (bus_rnw),
    .as_n        (as_n),
    .ds_n        (ds_n)
);

// File: tb/wrbus_master_test.sv
`timescale 1ns/1ps
module wrbus_master_test;

    localparam int SYNC = 2;
    localparam int LATE = 4;

    typedef struct packed {
        logic [23:0] addr;
        logic [2:0]  fc;
        logic [1:0]  siz;
        logic [15:0] data;
        logic [1:0]  ack;
        logic [7:0]  dly;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{24'h123456, 3'd5, 2'd1, 16'hA5C3, 2'b10, 8'd0},
        '{24'hFFFFFE, 3'd1, 2'd2, 16'h0001, 2'b01, 8'd1},
        '{24'h000000, 3'd7, 2'd0, 16'hFFFF, 2'b00, 8'd2},
        '{24'h800001, 3'd2, 2'd3, 16'h5A5A, 2'b10, 8'd5},
        '{24'h3C3C3C, 3'd6, 2'd1, 16'h8000, 2'b01, 8'd3},
        '{24'h0F0F0F, 3'd0, 2'd2, 16'h1234, 2'b00, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic [1:0]  req_siz = '0;
    logic [15:0] req_data = '0;
    logic        done;
    logic [23:0] bus_addr;
    logic [2:0]  bus_fc;
    logic [1:0]  bus_siz;
    logic [15:0] bus_data;
    logic        bus_data_oe;
    logic        bus_rnw;
    logic        as_n;
    logic        ds_n;
    logic [1:0]  ack_n = 2'b11;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wrbus_master #(.SYNC_STAGES(SYNC), .LATE_WAITS(LATE), .USE_S4(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_fc(req_fc), .req_siz(req_siz), .req_data(req_data),
        .done(done), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_siz(bus_siz),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe), .bus_rnw(bus_rnw),
        .as_n(as_n), .ds_n(ds_n), .ack_n(ack_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic run_write(input vec_t v, input bit hold_ack, input bit intrude);
        int n_rnw = -1, n_as = -1, n_oe = -1, n_ds = -1, n_end = -1, n_done = -1;
        int ds_cnt = 0, done_cnt = 0, extra = 0;
        int late = ((int'(v.dly) + SYNC) >= LATE) ? 1 : 0;
        while (!req_ready) @(negedge clk);
        req_addr = v.addr; req_fc = v.fc; req_siz = v.siz; req_data = v.data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 200; n++) begin
            if (!bus_rnw && n_rnw < 0) begin
                n_rnw = n;
                check(as_n == 1'b1, "R2 as_n high in S0", as_n, 1);
                check(bus_addr == v.addr && bus_fc == v.fc && bus_siz == v.siz,
                      "R2 fields in S0", {bus_addr, bus_fc, bus_siz}, {v.addr, v.fc, v.siz});
            end
            if (!as_n && n_as < 0) n_as = n;
            if (bus_data_oe && n_oe < 0) begin
                n_oe = n;
                check(bus_data == v.data, "R3 data on bus", bus_data, v.data);
            end
            if (!ds_n) begin
                if (n_ds < 0) n_ds = n;
                ds_cnt++;
                if (ds_cnt == int'(v.dly) + 1) ack_n = v.ack;
            end else if (n_ds >= 0 && n_end < 0) begin
                n_end = n;
                check(as_n && !bus_data_oe && !bus_rnw, "R7 S5 outputs",
                      {as_n, bus_data_oe, bus_rnw}, 3'b100);
                if (!hold_ack) ack_n = 2'b11;
            end
            if (done) begin
                done_cnt++;
                if (n_done < 0) n_done = n;
            end
            if (n_done >= 0 && n > n_done && !bus_rnw) extra++;
            if (intrude) begin
                if (n == 2) begin req_valid = 1'b1; req_addr = ~v.addr; end
                else if (n == 3) req_valid = 1'b0;
            end
            if (n_done >= 0 && n >= n_done + 4) break;
            @(negedge clk);
        end
        check(n_as == n_rnw + 1, "R3 AS one cycle after S0", n_as, n_rnw + 1);
        check(n_oe == n_as + 1, "R3 data one cycle after AS", n_oe, n_as + 1);
        check(n_ds == n_oe + 1, "R4 DS one cycle after data", n_ds, n_oe + 1);
        if (late != 0)
            check(ds_cnt == int'(v.dly) + 4, "R6 DS length with S4", ds_cnt, int'(v.dly) + 4);
        else
            check(ds_cnt == int'(v.dly) + 3, "R5 DS length direct", ds_cnt, int'(v.dly) + 3);
        check(done_cnt == 1 && n_done == n_end + 1, "R8 done pulse", n_done, n_end + 1);
        check(bus_data == 16'h0 && bus_rnw, "R7 idle after S5", {bus_rnw, bus_data}, 17'h10000);
        if (intrude) check(extra == 0, "R9 busy request ignored", extra, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(as_n && ds_n && !bus_data_oe && bus_rnw && !done, "R1 outputs in reset",
              {as_n, ds_n, bus_data_oe, bus_rnw, done}, 5'b11010);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        for (int i = 0; i < NV; i++) run_write(VECS[i], 1'b0, 1'b0);

        // R9 request pulse during a running transfer
        run_write('{24'hABCDEF, 3'd3, 2'd0, 16'hC0DE, 2'b10, 8'd1}, 1'b0, 1'b1);

        // R10 acknowledge still held after termination blocks a new start
        run_write('{24'h555555, 3'd4, 2'd3, 16'h7E7E, 2'b01, 8'd0}, 1'b1, 1'b0);
        req_addr = 24'h111111;
        req_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            check(!req_ready && bus_rnw && as_n, "R10 held ack blocks start",
                  {req_ready, bus_rnw, as_n}, 3'b011);
            @(negedge clk);
        end
        req_valid = 1'b0;
        ack_n = 2'b11;
        @(negedge clk);
        check(req_ready == 1'b0, "R10 ready still low one cycle after release", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready after sync delay", req_ready, 1);
        check(bus_rnw == 1'b1, "R10 no start while blocked", bus_rnw, 1);

        // one more transfer after the blocked period proves recovery
        run_write('{24'h00FF00, 3'd1, 2'd1, 16'h00FF, 2'b00, 8'd4}, 1'b0, 1'b0);

        summary();
        $finish;
    end

endmodule